// File: doc/BRIEF.md
# Core Sleep and Cycle-Stall Controller

This block holds one 32-bit control word per processor core and turns it into a stall signal for that core's pipeline. Software halts a core until an interrupt by setting a sleep flag. It can also load an 8-bit cycle budget and enable a countdown, so that the core is held for exactly that many clocks. While the countdown runs, reading the word returns the cycles that remain in the low byte.

Two hold flags gate the countdown stall. The auxiliary hold flag behaves like the primary one when it is set alone. When both are set, the auxiliary flag clears itself on the clock where the count reaches zero. Bit 28 and bits 26:8 are plain storage that software may use as it likes. They never influence the stall.

All cores share one write-data bus, and each core has its own write strobe. One read port selects a core by index. Each core has its own interrupt input and its own stall output.

Top module: `core_stall_ctrl`

## Requirements
- R1: After a synchronous reset every control word reads 0x00000000 and every stall output is low.
- R2: A write stores all 32 bits of `wr_data` into the addressed core's word, visible on `rd_data` from the next clock. Bits 28 and 26:8 hold their value until the next write and never change a stall output.
- R3: Bit 31 (sleep) drives the core's stall high. It is cleared on the clock edge where that core's `irq` is first sampled high after being sampled low. An interrupt input that is already high, or that stays high, does not clear a newly written sleep bit.
- R4: Bits 7:0 (count) decrease by exactly one per clock while bit 27 (start) is set and the count is nonzero. Otherwise the count holds.
- R5: The stall output is high exactly when bit 31 is set, or when the count is nonzero and bit 30 or bit 29 is set.
- R6: When bits 30 and 29 are both set, bit 29 clears on the same edge at which the count steps from 1 to 0. With bit 30 clear, bit 29 remains set after the count ends.
- R7: A write in a given cycle takes priority over both the countdown and the interrupt wake of that cycle.
- R8: Writing 0x68000080 holds stall high for exactly 128 consecutive clocks, after which the word reads 0x48000000.
- R9: The cores are independent: a write, an interrupt or a countdown on one core never alters another core's word or stall. `rd_sel` = k returns core k's word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | NUM_CORES | Per-core write strobe |
| wr_data | input | 32 | Control word to be written |
| rd_sel | input | SEL_W | Core index for the read port |
| rd_data | output | 32 | Control word of the selected core |
| irq | input | NUM_CORES | Per-core interrupt level |
| stall | output | NUM_CORES | Per-core pipeline hold |

## Verification
The assertions assume that `irq` and the write strobes are synchronous to `clk` and are stable around the sampling edge. They also assume that `rd_sel` names an existing core. The bench changes every input only on the falling edge, and it walks `rd_sel` only over valid core indices. Random counts are kept small so that countdowns finish often, and interrupt toggles are mixed with writes. This produces coincident write, wake and terminal-count cycles, alongside directed cases such as the 128-cycle hold and the sleep-with-interrupt-already-high case.

// File: rtl/csc_pkg.sv
// Package: shared widths and control-word bit positions for the stall controller.
// Assumes a 32-bit control word with the count in the low CNT_W bits.
package csc_pkg;
    localparam int WORD_W       = 32;
    localparam int CNT_W        = 8;
    localparam int SLEEP_BIT    = 31;
    localparam int HOLD_BIT     = 30;
    localparam int HOLD_AUX_BIT = 29;
    localparam int START_BIT    = 27;
    localparam int SEM_HI       = 26;
endpackage

// File: rtl/csc_irq_edge.sv
// Module: per-core rising-edge detector for the interrupt inputs.
// Assumes irq is synchronous to clk; the registered history starts low at reset.
module csc_irq_edge #(
    parameter int NUM_CORES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] irq,
    output logic [NUM_CORES-1:0] irq_rise
);
    logic [NUM_CORES-1:0] irq_q;

    // Remember last sampled interrupt level per core.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq;
    end

    // Rising edge = high now, low last clock.
    always_comb irq_rise = irq & ~irq_q;

    genvar g;
    for (g = 0; g < NUM_CORES; g++) begin : g_chk
        // R3
        rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_rise[g] |=> !irq_rise[g]);
    end
endmodule

// File: rtl/csc_countdown.sv
// Module: loadable down-counter for the cycle budget of one core.
// Assumes load has priority; run enables decrement only while nonzero.
module csc_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             ending
);
    // Load, decrement or hold the remaining-cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt <= '0;
        else if (load)                     cnt <= load_val;
        else if (run && (cnt != '0))       cnt <= cnt - 1'b1;
    end

    // Flags the clock at which the count steps from one to zero.
    always_comb ending = !load && run && (cnt == CNT_W'(1));

    // R4
    dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && run && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(cnt));
endmodule

// File: rtl/csc_core_slot.sv
// Module: control word and stall decision for a single core.
// Assumes irq_rise is a one-clock pulse; a write overrides all automatic updates.
module csc_core_slot
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              irq_rise,
    output logic [WORD_W-1:0] ctl_q,
    output logic              stall
);
    logic [WORD_W-1:CNT_W] flags_q;
    logic [CNT_W-1:0]      cnt;
    logic                  ending;
    logic                  run;

    // Countdown runs only while the start flag is set.
    always_comb run = flags_q[START_BIT];

    csc_countdown #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_en),
        .load_val (wr_data[CNT_W-1:0]),
        .run      (run),
        .cnt      (cnt),
        .ending   (ending)
    );

    // Upper flags: write, interrupt wake and auxiliary-hold self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (wr_en) begin
            flags_q <= wr_data[WORD_W-1:CNT_W];
        end else begin
            if (irq_rise) flags_q[SLEEP_BIT] <= 1'b0;
            if (ending && flags_q[HOLD_BIT] && flags_q[HOLD_AUX_BIT])
                flags_q[HOLD_AUX_BIT] <= 1'b0;
        end
    end

    // Readable word and hold decision.
    always_comb begin
        ctl_q = {flags_q, cnt};
        stall = flags_q[SLEEP_BIT] ||
                ((cnt != '0) && (flags_q[HOLD_BIT] || flags_q[HOLD_AUX_BIT]));
    end

    // R7
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctl_q == $past(wr_data));
    // R3
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && irq_rise) |=> !ctl_q[SLEEP_BIT]);
    // R3
    sleep_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !irq_rise && ctl_q[SLEEP_BIT]) |=> ctl_q[SLEEP_BIT]);
    // R6
    aux_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && ctl_q[HOLD_BIT] && ctl_q[HOLD_AUX_BIT] && ctl_q[START_BIT]
         && ctl_q[CNT_W-1:0] == CNT_W'(1)) |=> !ctl_q[HOLD_AUX_BIT]);
    // R2
    sem_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_q[START_BIT+1]) && $stable(ctl_q[SEM_HI:CNT_W]));
endmodule

// File: rtl/core_stall_ctrl.sv
// Module: top of the per-core sleep and cycle-stall controller.
// Assumes a shared write bus with per-core strobes and rd_sel below NUM_CORES.
module core_stall_ctrl
    import csc_pkg::*;
#(
    parameter int NUM_CORES = 2,
    localparam int SEL_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [SEL_W-1:0]     rd_sel,
    output logic [WORD_W-1:0]    rd_data,
    input  logic [NUM_CORES-1:0] irq,
    output logic [NUM_CORES-1:0] stall
);
    logic [NUM_CORES-1:0] irq_rise;
    logic [WORD_W-1:0]    ctl [NUM_CORES];

    csc_irq_edge #(.NUM_CORES(NUM_CORES)) edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq      (irq),
        .irq_rise (irq_rise)
    );

    genvar g;
    for (g = 0; g < NUM_CORES; g++) begin : g_core
        csc_core_slot slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en[g]),
            .wr_data  (wr_data),
            .irq_rise (irq_rise[g]),
            .ctl_q    (ctl[g]),
            .stall    (stall[g])
        );
    end

    // Read mux: selected core's word, zero for an out-of-range index.
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CORES; c++)
            if (rd_sel == SEL_W'(c)) rd_data = ctl[c];
    end
endmodule

// File: tb/core_stall_ctrl_tb.sv
`timescale 1ns/10ps
module core_stall_ctrl_tb_top;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] wr_en = '0;
    logic [31:0]   wr_data = '0;
    logic [0:0]    rd_sel = '0;
    logic [31:0]   rd_data;
    logic [NC-1:0] irq = '0;
    logic [NC-1:0] stall;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0]   m_reg [NC];
    logic [NC-1:0] m_irq;

    always #2 clk = ~clk;

    core_stall_ctrl #(.NUM_CORES(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .stall(stall)
    );

    function automatic logic [31:0] next_word(logic [31:0] cur, logic wr,
                                              logic [31:0] wd, logic rise);
        logic [31:0] n;
        if (wr) return wd;
        n = cur;
        if (cur[27] && cur[7:0] != 8'd0) begin
            n[7:0] = cur[7:0] - 8'd1;
            if (n[7:0] == 8'd0 && cur[30] && cur[29]) n[29] = 1'b0;
        end
        if (rise) n[31] = 1'b0;
        return n;
    endfunction

    function automatic logic exp_stall(logic [31:0] w);
        return w[31] || (w[7:0] != 8'd0 && (w[30] || w[29]));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive at falling edge, advance model, compare after rising edge.
    task automatic step(logic [NC-1:0] we, logic [31:0] wd, logic [NC-1:0] iv);
        logic [31:0] nx [NC];
        @(negedge clk);
        wr_en = we; wr_data = wd; irq = iv;
        for (int c = 0; c < NC; c++) begin
            nx[c] = next_word(m_reg[c], we[c], wd, iv[c] & ~m_irq[c]);
            m_irq[c] = iv[c];
        end
        @(posedge clk);
        #0.5;
        for (int c = 0; c < NC; c++) begin
            m_reg[c] = nx[c];
            rd_sel = 1'(c);
            #0.2;
            check("R2/R4/R9 word", rd_data, m_reg[c]);
            check("R5 stall", 32'(stall[c]), 32'(exp_stall(m_reg[c])));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin : main
        int n;
        void'($urandom(32'd1234));
        for (int c = 0; c < NC; c++) m_reg[c] = '0;
        m_irq = '0;
        repeat (3) @(posedge clk);
        #1;
        for (int c = 0; c < NC; c++) begin
            rd_sel = 1'(c); #0.2;
            check("R1 reset word", rd_data, 32'h0);
            check("R1 reset stall", 32'(stall[c]), 32'h0);
        end
        @(negedge clk); rst_n = 1'b1;

        // R8: 128-cycle hold then 0x48000000
        step(2'b01, 32'h6800_0080, 2'b00);
        n = stall[0] ? 1 : 0;
        for (int i = 0; i < 200; i++) begin
            step(2'b00, 32'h0, 2'b00);
            if (stall[0]) n++; else break;
        end
        check("R8 stall cycles", n, 128);
        rd_sel = 1'b0; #0.1;
        check("R8 final word", rd_data, 32'h4800_0000);
        rd_sel = 1'b1; #0.1;
        check("R9 other core untouched", rd_data, 32'h0);

        // R6: auxiliary hold alone stays set after count ends
        step(2'b01, 32'h2800_0005, 2'b00);
        repeat (6) step(2'b00, 32'h0, 2'b00);
        rd_sel = 1'b0; #0.1;
        check("R6 aux kept", rd_data, 32'h2800_0000);
        check("R6 no stall", 32'(stall[0]), 32'h0);

        // R4: count without start holds and stalls
        step(2'b01, 32'h4000_0003, 2'b00);
        repeat (5) step(2'b00, 32'h0, 2'b00);
        rd_sel = 1'b0; #0.1;
        check("R4 count held", rd_data, 32'h4000_0003);
        check("R5 held stall", 32'(stall[0]), 32'h1);

        // R2: storage bits readable and inert
        step(2'b01, 32'h17AB_CD00, 2'b00);
        repeat (3) step(2'b00, 32'h0, 2'b00);
        rd_sel = 1'b0; #0.1;
        check("R2 storage", rd_data, 32'h17AB_CD00);
        check("R2 no stall", 32'(stall[0]), 32'h0);

        // R3: sleep until irq rise; high level does not re-wake
        step(2'b10, 32'h8000_0000, 2'b00);
        repeat (4) step(2'b00, 32'h0, 2'b00);
        check("R3 asleep", 32'(stall[1]), 32'h1);
        step(2'b00, 32'h0, 2'b10);
        check("R3 woken", 32'(stall[1]), 32'h0);
        step(2'b10, 32'h8000_0000, 2'b10);
        repeat (4) step(2'b00, 32'h0, 2'b10);
        check("R3 level no wake", 32'(stall[1]), 32'h1);
        step(2'b00, 32'h0, 2'b00);
        step(2'b00, 32'h0, 2'b10);
        check("R3 second wake", 32'(stall[1]), 32'h0);

        // R7: write beats decrement and wake in the same cycle
        step(2'b01, 32'h0800_0010, 2'b00);
        step(2'b00, 32'h0, 2'b00);
        step(2'b01, 32'h0800_0003, 2'b00);
        rd_sel = 1'b0; #0.1;
        check("R7 write over count", rd_data, 32'h0800_0003);
        step(2'b00, 32'h0, 2'b00);
        step(2'b10, 32'h8000_0000, 2'b10);
        check("R7 write over wake", 32'(stall[1]), 32'h1);

        // Random mix, checked against the model every clock (R2 R4 R5 R6 R9)
        for (int i = 0; i < 3000; i++) begin
            logic [NC-1:0] we, iv;
            logic [31:0] wd;
            for (int c = 0; c < NC; c++) begin
                we[c] = ($urandom % 8) == 0;
                iv[c] = (($urandom % 6) == 0) ? ~irq[c] : irq[c];
            end
            wd = $urandom;
            wd[7:0] = 8'($urandom % 12);
            step(we, wd, iv);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule